// File: doc/BRIEF.md
# Phase-Frequency Detector with Programmable Antibacklash Overlap

This block compares two divided pulse streams, one from the reference divider and one from the feedback divider, and produces UP and DOWN requests for a charge pump that is not part of this block. Both inputs are treated as edge events. A fast oversampling clock samples them through a short synchronizer. A rising edge on the reference stream sets the UP flag. A rising edge on the feedback stream sets the DOWN flag. Each flag stays set until both flags are set together. Both are then cleared, but only after a programmable number of fast-clock cycles. Because of this delay, the two outputs always overlap for a minimum width and the detector has no dead zone around the locked condition.

A 2-bit select picks the overlap width from four parameterized fast-clock counts. Code 00 is the default and gives the shortest width. An input edge that arrives in the very cycle the clear is applied is remembered. It sets its flag again one cycle after the clear releases, so no comparison event is lost.

Top module: `pfd_abl_core`

## Requirements
- R1: A rising edge on the reference input sets UP. With the default of two synchronizer stages, UP goes high on the second fast-clock edge after the edge that first samples the input high, and it is still low just before that edge.
- R2: A rising edge on the feedback input sets DOWN, with the same latency as R1.
- R3: UP and DOWN fall only together, on the same fast-clock edge. A flag can be cleared only when both flags are high.
- R4: When both flags are high, they stay high together for exactly the selected number of fast-clock cycles before being cleared. The select codes map as follows: 2'b00 gives 2 cycles (the default), 2'b01 gives 3, 2'b10 gives 4 and 2'b11 gives 6.
- R5: For one comparison, the UP pulse width minus the DOWN pulse width equals the lead of the reference edge over the feedback edge, in fast-clock cycles. This difference is negative when the feedback edge comes first.
- R6: A rising edge that the detector sees in the cycle the clear is applied is not lost. Its flag is low for exactly one cycle after the clear and then goes high again.
- R7: While reset is asserted, and right after it is released, UP and DOWN are both low.
- R8: When both edges coincide, as in lock, both outputs pulse together for the selected width on every comparison. No comparison ever leaves both outputs silent.
- R9: Only rising edges act. An input that is still held high after the clear does not set its flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div_i | input | 1 | Reference-divider pulse stream |
| fb_div_i | input | 1 | Feedback-divider pulse stream |
| abl_sel_i | input | 2 | Overlap width select (see R4) |
| up_o | output | 1 | Charge-pump UP request |
| dn_o | output | 1 | Charge-pump DOWN request |

## Verification
A wrong overlap count, or a wrong decode of the select, shows up at the ports on the first comparison. The shorter of the two pulse widths is then not equal to the selected width. A flag that is cleared alone, or that never clears, shows up on the first comparison too. The pulse-width difference then no longer matches the injected phase lead, or the two falls are not on the same edge. If the one-cycle memory for an edge that lands on the clear is lost, the flag never returns high. This appears two cycles after that clear, and the detector then misses the next comparison pulse.

// File: rtl/pfd_abl_pkg.sv
package pfd_abl_pkg;

   typedef logic [1:0] abl_code_t;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_REF = 0;
   localparam int unsigned CH_FB  = 1;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o
);

   logic samp;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign samp = sig_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[k] <= 1'b0;
                  else        chain[k] <= sig_i;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[k] <= 1'b0;
                  else        chain[k] <= chain[k-1];
               end
            end
         end
         assign samp = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= samp;
   end

   assign rise_o = samp & ~prev;

endmodule

// File: rtl/pfd_flag.sv
module pfd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic clr_i,
   output logic q_o
);

   logic pend_q;
   logic set_eff;

   // an edge landing on the clear cycle is parked for one cycle
   assign set_eff = (rise_i & ~clr_i) | pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o    <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= rise_i & clr_i;
         if (clr_i)        q_o <= 1'b0;
         else if (set_eff) q_o <= 1'b1;
      end
   end

   // R1 / R2: an accepted edge sets the flag on the next edge
   p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && !clr_i) |=> q_o)
      else $error("flag not set after edge");

   // R3: a clear always drops the flag
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q_o)
      else $error("flag survived clear");

   // R6: edge during clear returns after exactly one low cycle
   p_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && clr_i) |=> (!q_o ##1 q_o))
      else $error("edge during clear was lost");

endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer
   import pfd_abl_pkg::*;
#(
   parameter int unsigned DLY_C0 = 2,
   parameter int unsigned DLY_C1 = 3,
   parameter int unsigned DLY_C2 = 4,
   parameter int unsigned DLY_C3 = 6
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      both_i,
   input  abl_code_t code_i,
   output logic      clr_o
);

   localparam int unsigned DMAX = max_of4(DLY_C0, DLY_C1, DLY_C2, DLY_C3);
   localparam int unsigned CW   = $clog2(DMAX + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      case (code_i)
         2'd0:    lim = CW'(DLY_C0 - 1);
         2'd1:    lim = CW'(DLY_C1 - 1);
         2'd2:    lim = CW'(DLY_C2 - 1);
         default: lim = CW'(DLY_C3 - 1);
      endcase
   end

   // >= keeps the clear coming even if the code shrinks mid-overlap
   assign clr_o = both_i && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!both_i || clr_o)  cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // R4: overlap is released only through the timed clear
   p_hold_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (both_i && !clr_o) |=> both_i)
      else $error("overlap ended before the delay expired");

endmodule

// File: rtl/pfd_abl_core.sv
module pfd_abl_core
   import pfd_abl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DLY_C0      = 2,
   parameter int unsigned DLY_C1      = 3,
   parameter int unsigned DLY_C2      = 4,
   parameter int unsigned DLY_C3      = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_div_i,
   input  logic       fb_div_i,
   input  logic [1:0] abl_sel_i,
   output logic       up_o,
   output logic       dn_o
);

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (DLY_C0 < 1 || DLY_C1 < 1 || DLY_C2 < 1 || DLY_C3 < 1) begin : g_bad_dly
         $error("every overlap width must be at least one cycle");
      end
   endgenerate

   logic [NUM_CH-1:0] raw;
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] flag;
   logic              clr;
   logic              both;

   assign raw[CH_REF] = ref_div_i;
   assign raw[CH_FB]  = fb_div_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (raw[c]),
            .rise_o (rise[c])
         );
         pfd_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .rise_i (rise[c]),
            .clr_i  (clr),
            .q_o    (flag[c])
         );
      end
   endgenerate

   assign both = &flag;

   pfd_abl_timer #(
      .DLY_C0 (DLY_C0),
      .DLY_C1 (DLY_C1),
      .DLY_C2 (DLY_C2),
      .DLY_C3 (DLY_C3)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .both_i (both),
      .code_i (abl_code_t'(abl_sel_i)),
      .clr_o  (clr)
   );

   assign up_o = flag[CH_REF];
   assign dn_o = flag[CH_FB];

   // R3: the two outputs never fall apart
   p_joint_fall_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up_o) |-> $fell(dn_o))
      else $error("UP fell alone");

   p_joint_fall_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dn_o) |-> $fell(up_o))
      else $error("DOWN fell alone");

endmodule

// File: tb/sim_pfd_abl_core.sv
module sim_pfd_abl_core;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WD_CYCLES  = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_div = 1'b0;
   logic       fb_div = 1'b0;
   logic [1:0] abl_sel = 2'b00;
   logic       up, dn;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int    q_ovl[$];
   int    q_diff[$];
   string q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pfd_abl_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_div_i (ref_div),
      .fb_div_i  (fb_div),
      .abl_sel_i (abl_sel),
      .up_o      (up),
      .dn_o      (dn)
   );

   function automatic int width_of(input logic [1:0] code);
      case (code)
         2'd0: return 2;
         2'd1: return 3;
         2'd2: return 4;
         default: return 6;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input int ovl, input int diff, input string tag);
      q_ovl.push_back(ovl);
      q_diff.push_back(diff);
      q_tag.push_back(tag);
   endtask

   // monitor: measures each joint pulse and compares with the scoreboard
   int uw = 0, dw = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (up) uw++;
         if (dn) dw++;
         if (!up && !dn && (uw > 0 || dw > 0)) begin
            if (q_ovl.size() == 0) begin
               chk("R5 unexpected pulse", 1, 0);
            end else begin
               int eo, ed;
               string t;
               eo = q_ovl.pop_front();
               ed = q_diff.pop_front();
               t  = q_tag.pop_front();
               chk({t, " R4 overlap"}, (uw < dw) ? uw : dw, eo);
               chk({t, " R5 width difference"}, uw - dw, ed);
            end
            uw = 0;
            dw = 0;
         end
      end
   end

   // driver: one comparison, lead > 0 means reference first
   task automatic compare(input logic [1:0] code, input int lead, input string tag);
      int d, alead;
      d = width_of(code);
      alead = (lead < 0) ? -lead : lead;
      abl_sel = code;
      push(d, lead, tag);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (i == 0) begin
            if (lead >= 0) ref_div = 1'b1;
            if (lead <= 0) fb_div = 1'b1;
         end
         if (i == alead && alead != 0) begin
            if (lead > 0) fb_div = 1'b1;
            else          ref_div = 1'b1;
         end
         if (i == 2) chk(lead >= 0 ? "R1 latency low" : "R2 latency low",
                         lead >= 0 ? int'(up) : int'(dn), 0);
         if (i == 3) chk(lead >= 0 ? "R1 latency high" : "R2 latency high",
                         lead >= 0 ? int'(up) : int'(dn), 1);
         if (i == 19) chk("R9 held level no reset", int'(up | dn), 0);
      end
      ref_div = 1'b0;
      fb_div  = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   // edge landing in the clear cycle (code 00, width 2)
   task automatic pend_case();
      abl_sel = 2'b00;
      push(2, 0, "R6 first");
      push(2, 4, "R6 second");
      @(negedge clk); ref_div = 1'b1; fb_div = 1'b1;
      @(negedge clk); ref_div = 1'b0;
      @(negedge clk); ref_div = 1'b1;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); chk("R6 gap low", int'(up), 0); fb_div = 1'b0;
      @(negedge clk); chk("R6 returns high", int'(up), 1);
      @(negedge clk); fb_div = 1'b1;
      repeat (8) @(negedge clk);
      ref_div = 1'b0;
      fb_div  = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R7 in reset", int'(up | dn), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 after reset", int'(up | dn), 0);

      for (int c = 0; c < 4; c++) begin
         compare(2'(c), 0, "R8 lock");
         compare(2'(c), 3, "ref lead");
         compare(2'(c), -2, "fb lead");
      end
      compare(2'b01, 1, "ref lead 1");
      compare(2'b11, -5, "fb lead 5");
      pend_case();
      compare(2'b10, 0, "R8 after pend");

      repeat (5) @(negedge clk);
      chk("R5 scoreboard drained", q_ovl.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule